// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a circular list of receive descriptors held in system memory and moves incoming frame bytes into the buffers they point to. Each descriptor occupies four consecutive 32-bit words. Word 0 holds the status and length, word 1 the buffer base address, word 2 is unused by the engine, and word 3 holds the address of the following descriptor. Software fills the ring and marks each entry as hardware-owned by setting bit 31 of its status word. It then writes the ring base address and pulses the start input.

For each descriptor, the engine reads the status word and checks ownership, then reads the buffer address. It accepts the frame one byte at a time and packs the bytes into 32-bit words, which it writes as they fill. At the end of the frame it writes a status word back with the owner bit cleared, which returns the entry to software. It raises a completion interrupt, follows the next pointer, and fetches the next entry. A descriptor still owned by software stops the engine with a descriptor-unavailable interrupt. Another start pulse makes it try the same entry again. Software drains finished entries until its own pointer equals the current-descriptor output.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the engine is halted: `rx_ready` and `mem_req` are low, `irq_stat` is zero, `irq` is low and `cur_desc` is zero.
- R2: A pulse on `ring_base_wr` loads `ring_base_data` into `cur_desc`. A `kick` pulse while halted starts a read of the status word at `cur_desc + 0`.
- R3: A status word with bit 31 set makes the engine read the buffer address at `cur_desc + 4` and then accept bytes. With bit 31 clear it sets `irq_stat` bit 10, halts with `rx_ready` low and issues no further memory requests, and leaves `cur_desc` unchanged. The next `kick` re-reads the same descriptor.
- R4: Frame byte k is written to address `buffer + 4*(k/4)` in byte lane k%4, bits `8*(k%4)+7 : 8*(k%4)`, little-endian. `mem_be` enables only the lanes that carry frame bytes, so a partial last word leaves the other lanes of memory untouched.
- R5: After the last data word, the engine writes one status word to `cur_desc + 0` with all four byte enables. Bits 15:0 of that word hold the number of bytes stored and bit 31 is zero.
- R6: In the written-back status word, bit 17 is the CRC error, bit 21 the alignment error and bit 22 the runt flag. All three are taken from the inputs that come with the last byte. Bit 20 (good) is set only when none of them is set and the frame was not truncated.
- R7: Bytes beyond `BUF_BYTES` are dropped without any memory write. The stored length is then `BUF_BYTES` and status bit 19 is set.
- R8: Each status write-back sets `irq_stat` bit 0. The engine then reads `cur_desc + 12`, loads that word into `cur_desc` and fetches the next descriptor's status.
- R9: Writing `irq_clr_data` with `irq_clr_wr` clears the `irq_stat` bits written as one and leaves the bits written as zero. `irq` is the OR of all `irq_stat` bits.
- R10: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high. A read takes `mem_rdata` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_wr | input | 1 | Load strobe for the ring base address |
| ring_base_data | input | ADDR_W | Address of the first descriptor |
| kick | input | 1 | Start pulse; resumes a halted engine |
| cur_desc | output | ADDR_W | Address of the descriptor being worked on |
| irq_clr_wr | input | 1 | Clear strobe for interrupt status |
| irq_clr_data | input | IRQ_W | Ones select status bits to clear |
| irq_stat | output | IRQ_W | Interrupt status (bit 0 frame done, bit 10 descriptor unavailable) |
| irq | output | 1 | Any interrupt status bit set |
| rx_valid | input | 1 | A frame byte is offered |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Offered byte ends the frame |
| rx_crc_bad | input | 1 | CRC error flag, sampled with the last byte |
| rx_align_bad | input | 1 | Alignment error flag, sampled with the last byte |
| rx_runt | input | 1 | Runt flag, sampled with the last byte |
| rx_ready | output | 1 | Engine accepts the offered byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench builds the engine with `BUF_BYTES` set to 16, so a 20-byte frame is enough to reach truncation and the too-long flag. A three-entry ring wraps back onto an entry software has not yet returned, which brings the descriptor-unavailable halt and the restart into reach within a few frames. A pseudo-random acknowledge pattern stalls reads, data writes and status writes at varied points. This exercises request holding, and the frames end on both full and partial words.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [2:0] {
    ST_HALT,
    ST_GET_OWN,
    ST_GET_BUF,
    ST_RECV,
    ST_PUT_WORD,
    ST_PUT_STAT,
    ST_GET_NEXT
  } walk_state_t;

  // status word bit positions (software decodes these)
  localparam int OWN_BIT   = 31;
  localparam int CRC_BIT   = 17;
  localparam int LONG_BIT  = 19;
  localparam int GOOD_BIT  = 20;
  localparam int ALIGN_BIT = 21;
  localparam int RUNT_BIT  = 22;

  // interrupt status bit positions
  localparam int IRQ_DONE_BIT    = 0;
  localparam int IRQ_UNAVAIL_BIT = 10;

  // descriptor word byte offsets
  localparam int OFS_STAT = 0;
  localparam int OFS_BUF  = 4;
  localparam int OFS_NEXT = 12;

  // status word returned to software; owner bit always left clear
  function automatic logic [31:0] pack_status(input logic [15:0] len,
                                              input logic crc,
                                              input logic align,
                                              input logic runt,
                                              input logic trunc);
    logic [31:0] s;
    s            = '0;
    s[15:0]      = len;
    s[CRC_BIT]   = crc;
    s[ALIGN_BIT] = align;
    s[RUNT_BIT]  = runt;
    s[LONG_BIT]  = trunc;
    s[GOOD_BIT]  = !(crc || align || runt || trunc);
    s[OWN_BIT]   = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [7:0]          byte_in,
  input  logic                clear,
  output logic [DATA_W-1:0]   word,
  output logic [DATA_W/8-1:0] be,
  output logic                at_top
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0] lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lane <= '0;
    else if (clear) lane <= '0;
    else if (take)  lane <= lane + 1'b1;
  end

  assign at_top = (lane == LW'(LANES - 1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] q;
    logic       v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        v <= 1'b0;
      end else if (clear) begin
        v <= 1'b0;
      end else if (take && lane == LW'(g)) begin
        q <= byte_in;
        v <= 1'b1;
      end
    end
    assign word[8*g +: 8] = q;
    assign be[g]          = v;
  end

  // a byte must never land in a word that is already full (R4)
  assert_no_overfill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !(&be));
  assert_no_take_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && clear));

endmodule

// File: rtl/rxd_irq.sv
module rxd_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] stat
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_data : '0;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_mask) | set_vec;
  end

  assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat) & ~stat)) |-> $past(clr_wr));
  assert_rise_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~$past(stat))) |-> (|$past(set_vec)));

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 1536,
  parameter int IRQ_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_base_wr,
  input  logic [ADDR_W-1:0] ring_base_data,
  input  logic              kick,
  output logic [ADDR_W-1:0] cur_desc,
  input  logic              irq_clr_wr,
  input  logic [IRQ_W-1:0]  irq_clr_data,
  output logic [IRQ_W-1:0]  irq_stat,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_last,
  input  logic              rx_crc_bad,
  input  logic              rx_align_bad,
  input  logic              rx_runt,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam logic [CNT_W-1:0]  BUF_LIM    = CNT_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] OFS_STAT_A = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] OFS_BUF_A  = ADDR_W'(OFS_BUF);
  localparam logic [ADDR_W-1:0] OFS_NEXT_A = ADDR_W'(OFS_NEXT);

  // byte offset of the word holding the most recently stored byte
  function automatic logic [CNT_W-1:0] word_offset(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] m;
    m      = c - 1'b1;
    m[1:0] = 2'b00;
    return m;
  endfunction

  walk_state_t       st;
  logic [ADDR_W-1:0] buf_addr;
  logic [CNT_W-1:0]  cnt;
  logic              f_crc, f_align, f_runt, f_trunc, last_seen;

  logic [31:0] pk_word;
  logic [3:0]  pk_be;
  logic        pk_top;
  logic [31:0] stat_word;

  // named internal events
  logic xfer, rx_take, store, drop, pk_clear;
  logic ev_unavail, ev_frame_done, ev_desc_step;
  logic [IRQ_W-1:0] irq_set;

  assign xfer          = mem_req && mem_ack;
  assign rx_ready      = (st == ST_RECV);
  assign rx_take       = rx_ready && rx_valid;
  assign store         = rx_take && (cnt < BUF_LIM);
  assign drop          = rx_take && !store;
  assign pk_clear      = (st == ST_PUT_WORD) && xfer;
  assign ev_unavail    = (st == ST_GET_OWN) && xfer && !mem_rdata[OWN_BIT];
  assign ev_frame_done = (st == ST_PUT_STAT) && xfer;
  assign ev_desc_step  = (st == ST_GET_NEXT) && xfer;
  assign stat_word     = pack_status(16'(cnt), f_crc, f_align, f_runt, f_trunc);

  always_comb begin
    irq_set                  = '0;
    irq_set[IRQ_DONE_BIT]    = ev_frame_done;
    irq_set[IRQ_UNAVAIL_BIT] = ev_unavail;
  end

  rxd_packer #(.DATA_W(32)) u_packer (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (store),
    .byte_in(rx_byte),
    .clear  (pk_clear),
    .word   (pk_word),
    .be     (pk_be),
    .at_top (pk_top)
  );

  rxd_irq #(.W(IRQ_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (irq_set),
    .clr_wr  (irq_clr_wr),
    .clr_data(irq_clr_data),
    .stat    (irq_stat)
  );

  assign irq = |irq_stat;

  // memory port, driven from state so a request holds until acknowledged
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc + OFS_STAT_A;
    mem_wdata = pk_word;
    mem_be    = 4'hF;
    unique case (st)
      ST_GET_OWN:  mem_req = 1'b1;
      ST_GET_BUF:  begin mem_req = 1'b1; mem_addr = cur_desc + OFS_BUF_A; end
      ST_GET_NEXT: begin mem_req = 1'b1; mem_addr = cur_desc + OFS_NEXT_A; end
      ST_PUT_WORD: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = buf_addr + ADDR_W'(word_offset(cnt));
        mem_be   = pk_be;
      end
      ST_PUT_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = stat_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HALT;
      cur_desc  <= '0;
      buf_addr  <= '0;
      cnt       <= '0;
      f_crc     <= 1'b0;
      f_align   <= 1'b0;
      f_runt    <= 1'b0;
      f_trunc   <= 1'b0;
      last_seen <= 1'b0;
    end else begin
      if (ring_base_wr) cur_desc <= ring_base_data;
      unique case (st)
        ST_HALT: if (kick) st <= ST_GET_OWN;
        ST_GET_OWN: if (xfer) st <= mem_rdata[OWN_BIT] ? ST_GET_BUF : ST_HALT;
        ST_GET_BUF: if (xfer) begin
          buf_addr  <= mem_rdata[ADDR_W-1:0];
          cnt       <= '0;
          f_crc     <= 1'b0;
          f_align   <= 1'b0;
          f_runt    <= 1'b0;
          f_trunc   <= 1'b0;
          last_seen <= 1'b0;
          st        <= ST_RECV;
        end
        ST_RECV: if (rx_take) begin
          if (store) cnt <= cnt + 1'b1;
          if (drop)  f_trunc <= 1'b1;
          if (rx_last) begin
            f_crc     <= rx_crc_bad;
            f_align   <= rx_align_bad;
            f_runt    <= rx_runt;
            last_seen <= 1'b1;
          end
          if ((store && pk_top) || (rx_last && (store || (|pk_be))))
            st <= ST_PUT_WORD;
          else if (rx_last)
            st <= ST_PUT_STAT;
        end
        ST_PUT_WORD: if (xfer) st <= last_seen ? ST_PUT_STAT : ST_RECV;
        ST_PUT_STAT: if (xfer) st <= ST_GET_NEXT;
        ST_GET_NEXT: if (xfer) begin
          cur_desc <= mem_rdata[ADDR_W-1:0];
          st       <= ST_GET_OWN;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  assert_unavail_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |=> (!rx_ready && !mem_req && irq_stat[IRQ_UNAVAIL_BIT]));
  assert_done_flags_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |=> irq_stat[IRQ_DONE_BIT]);
  assert_desc_moves_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_desc) |-> ($past(ring_base_wr) || $past(ev_desc_step)));
  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= BUF_LIM);
  assert_write_inside_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PUT_WORD) |-> (word_offset(cnt) < BUF_LIM));

endmodule

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int BUF = 16;
  localparam int IW  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ring_base_wr;
  logic [AW-1:0] ring_base_data;
  logic          kick;
  logic [AW-1:0] cur_desc;
  logic          irq_clr_wr;
  logic [IW-1:0] irq_clr_data;
  logic [IW-1:0] irq_stat;
  logic          irq;
  logic          rx_valid, rx_last, rx_crc_bad, rx_align_bad, rx_runt, rx_ready;
  logic [7:0]    rx_byte;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_ring #(.ADDR_W(AW), .BUF_BYTES(BUF), .IRQ_W(IW)) u_rx_desc_ring (
    .clk(clk), .rst_n(rst_n),
    .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data), .kick(kick),
    .cur_desc(cur_desc),
    .irq_clr_wr(irq_clr_wr), .irq_clr_data(irq_clr_data), .irq_stat(irq_stat), .irq(irq),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
    .rx_crc_bad(rx_crc_bad), .rx_align_bad(rx_align_bad), .rx_runt(rx_runt),
    .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem_w [0:1023];
  assign mem_rdata = mem_w[mem_addr[11:2]];

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model: ordered list of memory writes the engine must make
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  logic [3:0]  exp_be[$];
  string       exp_tag[$];
  logic [31:0] rd_log[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[8*l +: 8] = be[l] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // memory with pseudo-random acknowledge, compared against the model every clock
  logic [7:0]  lfsr = 8'h5B;
  bit          hold_pending = 0;
  logic [31:0] hold_addr = '0;
  initial mem_ack = 1'b0;

  always @(negedge clk) begin
    lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ack = lfsr[0] | lfsr[2];
    if (rst_n === 1'b1) begin
      if (hold_pending)
        check(mem_req && mem_addr == hold_addr, "R10 request held", mem_addr, hold_addr);
      hold_pending = mem_req && !mem_ack;
      hold_addr    = mem_addr;
      if (mem_req && mem_ack && mem_we) begin
        if (exp_addr.size() == 0) begin
          check(1'b0, "R5 unexpected write", mem_addr, 32'h0);
        end else begin
          logic [31:0] a, d;
          logic [3:0]  b;
          string       t;
          a = exp_addr.pop_front();
          d = exp_data.pop_front();
          b = exp_be.pop_front();
          t = exp_tag.pop_front();
          check(mem_addr == a, {t, " write address"}, mem_addr, a);
          check(mem_be == b, {t, " byte enables"}, {28'h0, mem_be}, {28'h0, b});
          check((mem_wdata & lane_mask(b)) == (d & lane_mask(b)), {t, " write data"},
                mem_wdata & lane_mask(b), d & lane_mask(b));
        end
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem_w[mem_addr[11:2]][8*l +: 8] = mem_wdata[8*l +: 8];
      end else if (mem_req && mem_ack) begin
        rd_log.push_back(mem_addr);
      end
    end
  end

  task automatic expect_frame(input logic [31:0] desc, input logic [31:0] bufa,
                              input int n, input bit crc, input bit align,
                              input bit runt, input logic [7:0] b0,
                              output logic [31:0] status);
    int stored;
    bit trunc;
    stored = (n > BUF) ? BUF : n;
    trunc  = (n > BUF);
    for (int w = 0; w < (stored + 3) / 4; w++) begin
      logic [31:0] d;
      logic [3:0]  b;
      d = '0;
      b = '0;
      for (int l = 0; l < 4; l++) begin
        if (4*w + l < stored) begin
          d[8*l +: 8] = b0 + 8'(4*w + l);
          b[l] = 1'b1;
        end
      end
      exp_addr.push_back(bufa + 32'(4*w));
      exp_data.push_back(d);
      exp_be.push_back(b);
      exp_tag.push_back("R4");
    end
    status = 32'(stored);
    status[17] = crc;
    status[19] = trunc;
    status[21] = align;
    status[22] = runt;
    status[20] = !(crc || align || runt || trunc);
    exp_addr.push_back(desc);
    exp_data.push_back(status);
    exp_be.push_back(4'hF);
    exp_tag.push_back("R5");
  endtask

  task automatic send_frame(input int n, input logic [7:0] b0, input bit crc,
                            input bit align, input bit runt);
    for (int k = 0; k < n; k++) begin
      bit ok;
      rx_valid     = 1'b1;
      rx_byte      = b0 + 8'(k);
      rx_last      = (k == n - 1);
      rx_crc_bad   = rx_last & crc;
      rx_align_bad = rx_last & align;
      rx_runt      = rx_last & runt;
      do begin
        ok = rx_ready;
        @(negedge clk);
      end while (!ok);
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    rx_crc_bad = 1'b0;
    rx_align_bad = 1'b0;
    rx_runt = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      if (rx_ready || irq_stat[10]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_reads(input int n);
    for (int i = 0; i < 200; i++) begin
      if (rd_log.size() >= n) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic clear_irq(input logic [IW-1:0] v);
    irq_clr_wr   = 1'b1;
    irq_clr_data = v;
    @(negedge clk);
    irq_clr_wr   = 1'b0;
    irq_clr_data = '0;
  endtask

  task automatic set_desc(input logic [31:0] d, input logic [31:0] b, input logic [31:0] nx);
    mem_w[d[11:2]]       = 32'h8000_0000;
    mem_w[d[11:2] + 1]   = b;
    mem_w[d[11:2] + 2]   = 32'h0;
    mem_w[d[11:2] + 3]   = nx;
  endtask

  initial begin
    logic [31:0] st_a, st_b, st_c, st_d;
    int snap;
    rst_n = 1'b0;
    ring_base_wr = 1'b0; ring_base_data = '0; kick = 1'b0;
    irq_clr_wr = 1'b0; irq_clr_data = '0;
    rx_valid = 1'b0; rx_byte = '0; rx_last = 1'b0;
    rx_crc_bad = 1'b0; rx_align_bad = 1'b0; rx_runt = 1'b0;
    for (int i = 0; i < 1024; i++) mem_w[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq_stat == '0, "R1 irq_stat", 32'(irq_stat), 32'h0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
    check(cur_desc == '0, "R1 cur_desc", cur_desc, 32'h0);
    check(rx_ready == 1'b0, "R1 rx_ready", 32'(rx_ready), 32'h0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);

    set_desc(32'h100, 32'h400, 32'h120);
    set_desc(32'h120, 32'h480, 32'h140);
    set_desc(32'h140, 32'h500, 32'h100);
    mem_w[32'h404 >> 2] = 32'h5A5A_5A5A;
    mem_w[32'h490 >> 2] = 32'hDEAD_BEEF;

    // R2 base load and start
    ring_base_wr = 1'b1; ring_base_data = 32'h100;
    @(negedge clk);
    ring_base_wr = 1'b0;
    check(cur_desc == 32'h100, "R2 base load", cur_desc, 32'h100);
    pulse_kick();
    wait_reads(2);
    check(rd_log.size() >= 2 && rd_log[0] == 32'h100, "R2 first read at status word",
          rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h100);
    check(rd_log.size() >= 2 && rd_log[1] == 32'h104, "R3 owned so buffer word read",
          rd_log.size() > 1 ? rd_log[1] : 32'hFFFF_FFFF, 32'h104);

    // frame A: 7 bytes, good, partial last word (R4 R5 R8)
    expect_frame(32'h100, 32'h400, 7, 0, 0, 0, 8'h10, st_a);
    send_frame(7, 8'h10, 0, 0, 0);
    wait_idle();
    check(exp_addr.size() == 0, "R5 all writes made", 32'(exp_addr.size()), 32'h0);
    check(mem_w[32'h100 >> 2] == st_a, "R5 status word A", mem_w[32'h100 >> 2], st_a);
    check(mem_w[32'h400 >> 2] == 32'h1312_1110, "R4 first word", mem_w[32'h400 >> 2], 32'h1312_1110);
    check(mem_w[32'h404 >> 2] == 32'h5A16_1514, "R4 partial word lanes", mem_w[32'h404 >> 2], 32'h5A16_1514);
    check(irq_stat[0] == 1'b1, "R8 done bit", 32'(irq_stat), 32'h1);
    check(irq == 1'b1, "R9 irq is OR", 32'(irq), 32'h1);
    check(cur_desc == 32'h120, "R8 next pointer", cur_desc, 32'h120);

    // R9 write-one-to-clear
    clear_irq('0);
    check(irq_stat == 16'h0001, "R9 zero write keeps bits", 32'(irq_stat), 32'h1);
    clear_irq(16'h0001);
    check(irq_stat == 16'h0000, "R9 one write clears", 32'(irq_stat), 32'h0);
    check(irq == 1'b0, "R9 irq low", 32'(irq), 32'h0);

    // frame B: 20 bytes into a 16-byte buffer (R7)
    expect_frame(32'h120, 32'h480, 20, 0, 0, 0, 8'h40, st_b);
    send_frame(20, 8'h40, 0, 0, 0);
    wait_idle();
    check(mem_w[32'h120 >> 2] == st_b, "R7 truncated status", mem_w[32'h120 >> 2], st_b);
    check(mem_w[32'h490 >> 2] == 32'hDEAD_BEEF, "R7 no write past buffer",
          mem_w[32'h490 >> 2], 32'hDEAD_BEEF);
    check(cur_desc == 32'h140, "R8 second step", cur_desc, 32'h140);

    // frame C: 4 bytes with CRC error, then ring wraps onto a returned entry
    expect_frame(32'h140, 32'h500, 4, 1, 0, 0, 8'h80, st_c);
    send_frame(4, 8'h80, 1, 0, 0);
    wait_idle();
    check(mem_w[32'h140 >> 2] == st_c, "R6 crc status", mem_w[32'h140 >> 2], st_c);
    check(irq_stat[10] == 1'b1, "R3 unavailable bit", 32'(irq_stat), 32'h401);
    check(rx_ready == 1'b0, "R3 halted not ready", 32'(rx_ready), 32'h0);
    check(cur_desc == 32'h100, "R3 cur_desc kept", cur_desc, 32'h100);
    snap = rd_log.size();
    repeat (20) @(negedge clk);
    check(rd_log.size() == snap && !mem_req, "R3 no requests while halted",
          32'(rd_log.size()), 32'(snap));

    // give entry back, clear, restart: frame D 1 byte, runt + alignment
    mem_w[32'h100 >> 2] = 32'h8000_0000;
    clear_irq('1);
    check(irq_stat == '0, "R9 clear all", 32'(irq_stat), 32'h0);
    rd_log.delete();
    pulse_kick();
    wait_reads(1);
    check(rd_log.size() >= 1 && rd_log[0] == 32'h100, "R3 kick retries same entry",
          rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h100);
    expect_frame(32'h100, 32'h400, 1, 0, 1, 1, 8'hC0, st_d);
    send_frame(1, 8'hC0, 0, 1, 1);
    wait_idle();
    check(mem_w[32'h100 >> 2] == st_d, "R6 runt and align status", mem_w[32'h100 >> 2], st_d);
    check(exp_addr.size() == 0, "R5 no missing writes", 32'(exp_addr.size()), 32'h0);
    check(cur_desc == 32'h120 && irq_stat[10], "R3 stops on next returned entry",
          cur_desc, 32'h120);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule